// File: doc/BRIEF.md
# Byte and Word Load-Store Unit

This unit is the data-memory end of a load-store processor pipeline. Each request carries a memory opcode, a base register value, a 16-bit signed offset and the store data. The unit adds the base and the sign-extended offset to form a byte address, then reads or writes an internal array of bytes. It can read or write one byte or a whole 32-bit word.

Load results are registered and appear exactly one clock after the request, already formatted for the register file. A byte load is sign-extended to 32 bits. A word is assembled from four consecutive bytes. By default the byte at the lowest address is the most significant byte of the word, and a parameter can reverse this order. The array is cleared by reset. The address wraps modulo the array size, which is a power-of-two parameter. A word access whose address is not a multiple of four is refused and flagged.

Top module: `byte_word_lsu`

## Requirements
- R1: The byte address is `base_val` plus the sign-extended `offset`, taken modulo `MEM_BYTES` (256 by default), so a negative offset and wrap-around both select the expected byte.
- R2: Opcode 0x20 returns the addressed byte with bit 7 copied into bits 31..8.
- R3: Opcode 0x23 returns the 32-bit word at an address that is a multiple of four. With the default order, the byte at the lowest address lands in bits 31..24 and the byte at address+3 lands in bits 7..0.
- R4: Opcode 0x28 writes bits 7..0 of `store_data` to the addressed byte and leaves the other three bytes of that word unchanged.
- R5: Opcode 0x2b writes all four bytes of `store_data`, with bits 31..24 going to the lowest address under the default order.
- R6: After a load request, `load_valid` is high for exactly the next cycle and `load_data` holds the result in that cycle. A store request or an idle cycle leaves `load_valid` low in the following cycle.
- R7: A word load or word store whose address has bit 1 or bit 0 set raises `misalign_err` in the next cycle and writes nothing. A misaligned word load also returns zero data, with `load_valid` high.
- R8: While `rst_n` is low at a clock edge, every byte of the array is cleared, and `load_valid`, `load_data` and `misalign_err` are cleared. A load from a location not written since reset returns zero.
- R9: A request with any other opcode writes nothing, raises neither `load_valid` nor `misalign_err`, and leaves the memory contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset; clears the array and the outputs |
| req_valid | input | 1 | A request is presented in this cycle |
| req_op | input | 6 | Memory opcode: 0x20, 0x23, 0x28 or 0x2b |
| base_val | input | 32 | Base register value |
| offset | input | 16 | Signed immediate offset |
| store_data | input | 32 | Register value to store |
| load_valid | output | 1 | Load result is present in this cycle |
| load_data | output | 32 | Formatted load result |
| misalign_err | output | 1 | The previous request was a misaligned word access |

## Verification
A wrong byte lane, a wrong significance order or a lost sign extension inside the unit stays hidden until some later load reads the affected location. It then shows on `load_data` one cycle after that load request. For this reason every store in the vector walk is followed by word and byte loads of the same and neighbouring addresses. A store that leaks into untouched bytes is caught the same way, as are a misaligned or unknown request that writes anyway and a reset that fails to clear memory. A control fault, such as a lost or extra response cycle or a stuck error flag, shows on `load_valid` or `misalign_err` in the very next cycle.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    // Memory opcodes understood by the unit
    localparam logic [5:0] OP_LOAD_BYTE  = 6'h20;
    localparam logic [5:0] OP_LOAD_WORD  = 6'h23;
    localparam logic [5:0] OP_STORE_BYTE = 6'h28;
    localparam logic [5:0] OP_STORE_WORD = 6'h2b;

    localparam int LANES = 4;

    typedef logic [7:0] byte_t;

    // Decoded request kind
    typedef struct packed {
        logic ld_byte;
        logic ld_word;
        logic st_byte;
        logic st_word;
    } op_kind_t;
endpackage

// File: rtl/lsu_agen.sv
// lsu_agen: decodes the memory opcode and forms the byte address.
// Assumes: ADDR_W <= 32, so the address wraps at the array size.
// Produces the word index, the byte lane and an alignment flag.
module lsu_agen #(
    parameter int ADDR_W = 8,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic [5:0]         op,
    input  logic [31:0]        base,
    input  logic [15:0]        imm,
    output lsu_pkg::op_kind_t  kind,
    output logic [IDX_W-1:0]   idx,
    output logic [1:0]         lane,
    output logic               aligned
);
    import lsu_pkg::*;

    logic [31:0] eff;
    logic        unused_hi;

    // Base plus sign-extended immediate, full width
    always_comb begin
        eff       = base + {{16{imm[15]}}, imm};
        unused_hi = ^eff[31:ADDR_W];
        idx       = eff[ADDR_W-1:2];
        lane      = eff[1:0];
        aligned   = (eff[1:0] == 2'b00);
    end

    // Opcode decode; unknown opcodes set no flag
    always_comb begin
        kind.ld_byte = (op == OP_LOAD_BYTE);
        kind.ld_word = (op == OP_LOAD_WORD);
        kind.st_byte = (op == OP_STORE_BYTE);
        kind.st_word = (op == OP_STORE_WORD);
    end
endmodule

// File: rtl/lsu_bank.sv
// lsu_bank: one byte lane of the array, holding WORDS bytes.
// Assumes: synchronous active-low reset clears every entry.
// Read is combinational; write happens on the clock edge.
module lsu_bank #(
    parameter int WORDS = 64,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [7:0]        wbyte,
    output logic [7:0]        rbyte
);
    logic [7:0] mem [WORDS];

    // Clear on reset, else write the addressed entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
        end else if (we) begin
            mem[idx] <= wbyte;
        end
    end

    // Asynchronous read of the addressed entry
    always_comb rbyte = mem[idx];

    // A write lands in the entry it addressed (R4, R5)
    assert_bank_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(idx)] == $past(wbyte));

    // After a reset edge the addressed entry reads zero (R8)
    assert_bank_cleared_R8: assert property (@(posedge clk)
        !rst_n |=> rbyte == 8'h00 || !$past(!rst_n));
endmodule

// File: rtl/lsu_ldfmt.sv
// lsu_ldfmt: formats the four lane bytes into a register value.
// Assumes: BIG_END=1 puts lane 0 in bits 31..24.
// Byte loads are sign-extended; misaligned word loads give zero.
module lsu_ldfmt #(
    parameter bit BIG_END = 1'b1
) (
    input  logic [3:0][7:0] lane_bytes,
    input  logic [1:0]      lane,
    input  logic            is_byte,
    input  logic            aligned,
    output logic [31:0]     value
);
    logic [31:0] word;
    logic [7:0]  sel;

    // Place each lane at its significance
    always_comb begin
        for (int l = 0; l < 4; l++) begin
            word[8*(BIG_END ? 3 - l : l) +: 8] = lane_bytes[l];
        end
    end

    // Pick byte or word, then extend or zero
    always_comb begin
        sel = lane_bytes[lane];
        if (is_byte)      value = {{24{sel[7]}}, sel};
        else if (aligned) value = word;
        else              value = 32'h0;
    end
endmodule

// File: rtl/byte_word_lsu.sv
// byte_word_lsu: load-store unit over a byte-addressed array.
// Assumes: MEM_BYTES is a power of two and at least 8.
// Loads answer one cycle after the request; stores answer nothing.
module byte_word_lsu #(
    parameter int MEM_BYTES = 256,
    parameter bit BIG_END   = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic [5:0]  req_op,
    input  logic [31:0] base_val,
    input  logic [15:0] offset,
    input  logic [31:0] store_data,
    output logic        load_valid,
    output logic [31:0] load_data,
    output logic        misalign_err
);
    import lsu_pkg::*;

    localparam int ADDR_W = $clog2(MEM_BYTES);
    localparam int WORDS  = MEM_BYTES / LANES;
    localparam int IDX_W  = ADDR_W - 2;

    op_kind_t         kind;
    logic [IDX_W-1:0] idx;
    logic [1:0]       lane;
    logic             aligned;
    logic [3:0]       lane_we;
    logic [3:0][7:0]  lane_wr;
    logic [3:0][7:0]  lane_rd;
    logic [31:0]      fmt_value;
    logic             is_load;
    logic             word_op;
    logic             rsp_byte;

    lsu_agen #(.ADDR_W(ADDR_W)) u_agen (
        .op(req_op), .base(base_val), .imm(offset),
        .kind(kind), .idx(idx), .lane(lane), .aligned(aligned)
    );

    // Request class helpers
    always_comb begin
        is_load = kind.ld_byte | kind.ld_word;
        word_op = kind.ld_word | kind.st_word;
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int SIG = BIG_END ? 3 - l : l;

        // Per-lane write enable and data
        always_comb begin
            lane_we[l] = req_valid &&
                         ((kind.st_word && aligned) ||
                          (kind.st_byte && lane == 2'(l)));
            lane_wr[l] = kind.st_word ? store_data[8*SIG +: 8] : store_data[7:0];
        end

        lsu_bank #(.WORDS(WORDS)) u_bank (
            .clk(clk), .rst_n(rst_n), .we(lane_we[l]), .idx(idx),
            .wbyte(lane_wr[l]), .rbyte(lane_rd[l])
        );
    end

    lsu_ldfmt #(.BIG_END(BIG_END)) u_fmt (
        .lane_bytes(lane_rd), .lane(lane), .is_byte(kind.ld_byte),
        .aligned(aligned), .value(fmt_value)
    );

    // Register the response and the error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_valid   <= 1'b0;
            load_data    <= 32'h0;
            misalign_err <= 1'b0;
            rsp_byte     <= 1'b0;
        end else begin
            load_valid   <= req_valid && is_load;
            load_data    <= (req_valid && is_load) ? fmt_value : 32'h0;
            misalign_err <= req_valid && word_op && !aligned;
            rsp_byte     <= req_valid && kind.ld_byte;
        end
    end

    // Loads answer in the next cycle (R6)
    assert_load_answers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_op == OP_LOAD_BYTE || req_op == OP_LOAD_WORD)) |=> load_valid);

    // Stores and unknown opcodes give no response (R6, R9)
    assert_no_answer_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op != OP_LOAD_BYTE && req_op != OP_LOAD_WORD) |=> !load_valid);

    // Byte results carry bit 7 upward (R2)
    assert_sign_ext_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_valid && rsp_byte) |-> load_data[31:8] == {24{load_data[7]}});

    // Misaligned word accesses write no lane (R7)
    assert_misalign_no_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_op == OP_STORE_WORD && base_val[1:0] != offset[1:0] + 2'(0)
         && ((base_val[1:0] + offset[1:0]) != 2'b00)) |-> lane_we == 4'b0000);

    // A raised error on a load carries zero data (R7)
    assert_err_zero_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (misalign_err && load_valid) |-> load_data == 32'h0);

    // At most one lane written by a byte store (R4)
    assert_one_lane_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_op == OP_STORE_BYTE) |-> $onehot0(lane_we));
endmodule

// File: tb/sim_byte_word_lsu.sv
module sim_byte_word_lsu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [5:0]  req_op = 6'h0;
    logic [31:0] base_val = 32'h0;
    logic [15:0] offset = 16'h0;
    logic [31:0] store_data = 32'h0;
    logic        load_valid;
    logic [31:0] load_data;
    logic        misalign_err;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    byte_word_lsu u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .base_val(base_val), .offset(offset), .store_data(store_data),
        .load_valid(load_valid), .load_data(load_data), .misalign_err(misalign_err)
    );

    typedef struct packed {
        logic [3:0]  rq;
        logic        v;
        logic [5:0]  op;
        logic [31:0] base;
        logic [15:0] off;
        logic [31:0] wd;
        logic        ev;
        logic [31:0] ed;
        logic        ee;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{4'd5, 1'b1, 6'h2b, 32'h10,  16'h0,    32'h11223344, 1'b0, 32'h0,        1'b0}, // R5 word store
        '{4'd3, 1'b1, 6'h23, 32'h10,  16'h0,    32'h0,        1'b1, 32'h11223344, 1'b0}, // R3 word load
        '{4'd6, 1'b0, 6'h23, 32'h10,  16'h0,    32'h0,        1'b0, 32'h0,        1'b0}, // R6 idle after load
        '{4'd5, 1'b1, 6'h20, 32'h10,  16'h0,    32'h0,        1'b1, 32'h11,       1'b0}, // R5 MSB at low address
        '{4'd5, 1'b1, 6'h20, 32'h13,  16'h0,    32'h0,        1'b1, 32'h44,       1'b0}, // R5 LSB at address+3
        '{4'd4, 1'b1, 6'h28, 32'h20,  16'hFFF2, 32'hFFFFFF80, 1'b0, 32'h0,        1'b0}, // R4 byte store at 0x12
        '{4'd4, 1'b1, 6'h23, 32'h10,  16'h0,    32'h0,        1'b1, 32'h11228044, 1'b0}, // R4 neighbours intact
        '{4'd2, 1'b1, 6'h20, 32'h12,  16'h0,    32'h0,        1'b1, 32'hFFFFFF80, 1'b0}, // R2 negative byte
        '{4'd1, 1'b1, 6'h20, 32'h8,   16'h9,    32'h0,        1'b1, 32'h22,       1'b0}, // R1 positive offset
        '{4'd7, 1'b1, 6'h23, 32'h11,  16'h0,    32'h0,        1'b1, 32'h0,        1'b1}, // R7 misaligned load
        '{4'd7, 1'b1, 6'h2b, 32'h15,  16'h0,    32'hDEADBEEF, 1'b0, 32'h0,        1'b1}, // R7 misaligned store
        '{4'd7, 1'b1, 6'h23, 32'h14,  16'h0,    32'h0,        1'b1, 32'h0,        1'b0}, // R7 nothing written
        '{4'd8, 1'b1, 6'h20, 32'h17,  16'h0,    32'h0,        1'b1, 32'h0,        1'b0}, // R8 unwritten byte
        '{4'd9, 1'b1, 6'h00, 32'h10,  16'h0,    32'hFFFFFFFF, 1'b0, 32'h0,        1'b0}, // R9 unknown opcode
        '{4'd9, 1'b1, 6'h2a, 32'h10,  16'h0,    32'hFFFFFFFF, 1'b0, 32'h0,        1'b0}, // R9 near-store opcode
        '{4'd9, 1'b1, 6'h23, 32'h10,  16'h0,    32'h0,        1'b1, 32'h11228044, 1'b0}, // R9 memory unchanged
        '{4'd1, 1'b1, 6'h2b, 32'h1FC, 16'h0,    32'hCAFEF00D, 1'b0, 32'h0,        1'b0}, // R1 wrap on store
        '{4'd1, 1'b1, 6'h23, 32'h100, 16'hFFFC, 32'h0,        1'b1, 32'hCAFEF00D, 1'b0}, // R1 wrap, negative offset
        '{4'd2, 1'b1, 6'h20, 32'hFD,  16'h0,    32'h0,        1'b1, 32'hFFFFFFFE, 1'b0}, // R2 byte 0xFE
        '{4'd2, 1'b1, 6'h20, 32'hFF,  16'h0,    32'h0,        1'b1, 32'h0D,       1'b0}, // R2 positive byte
        '{4'd6, 1'b1, 6'h28, 32'h30,  16'h0,    32'h000000A5, 1'b0, 32'h0,        1'b0}, // R6 store no answer
        '{4'd4, 1'b1, 6'h23, 32'h30,  16'h0,    32'h0,        1'b1, 32'hA5000000, 1'b0}  // R4 single byte
    };

    task automatic check(input int rq, input string what, input logic [33:0] act, input logic [33:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [5:0] op, input logic [31:0] b,
                         input logic [15:0] o, input logic [31:0] d);
        req_valid = v; req_op = op; base_val = b; offset = o; store_data = d;
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 outputs cleared by reset
        check(8, "reset outputs", {load_valid, misalign_err, load_data}, 34'h0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(TBL[i].v, TBL[i].op, TBL[i].base, TBL[i].off, TBL[i].wd);
            @(posedge clk);
            @(negedge clk);
            check(int'(TBL[i].rq), $sformatf("vector %0d", i),
                  {load_valid, misalign_err, load_data},
                  {TBL[i].ev, TBL[i].ee, TBL[i].ed});
        end
        drive(1'b0, 6'h0, 32'h0, 16'h0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        // R6 valid lasts one cycle only
        check(6, "valid drops", {load_valid, misalign_err, 32'h0}, 34'h0);

        // R8 mid-run reset clears stored data
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b1, 6'h23, 32'h10, 16'h0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check(8, "cleared word", {load_valid, misalign_err, load_data}, {2'b10, 32'h0});
        drive(1'b1, 6'h23, 32'hFC, 16'h0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check(8, "cleared wrap word", {load_valid, misalign_err, load_data}, {2'b10, 32'h0});

        // R7 error flag is one cycle wide
        drive(1'b1, 6'h2b, 32'h2, 16'h0, 32'h12345678);
        @(posedge clk);
        @(negedge clk);
        check(7, "err raised", {load_valid, misalign_err, 32'h0}, {2'b01, 32'h0});
        drive(1'b1, 6'h23, 32'h0, 16'h0, 32'h0);
        @(posedge clk);
        @(negedge clk);
        check(7, "err cleared, no write", {load_valid, misalign_err, load_data}, {2'b10, 32'h0});
        drive(1'b0, 6'h0, 32'h0, 16'h0, 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule